// File: doc/BRIEF.md
# Channel Summing Slot Mapper

This block sits behind an eight-channel converter front end and turns one frame of eight signed 32-bit channel samples into eight output slot words. A two-bit summing mode picks how channels reach the slots: each channel on its own slot, two four-channel averages, four two-channel averages, or a single eight-channel average. Every channel has a power-enable bit, and a channel that is switched off counts as zero wherever it is used.

Slots that the selected mode leaves empty are filled according to the output format. In the plain format they are zero. In the wide time-division formats they carry the matching word from a cascade input, so a second device can chain its data through. In the 128-bit-frame format only the lower four slots take cascade words, and the upper four stay zero. The mode and power bits are taken from a write port only while a soft reset input is held high. While soft reset is high, frames are not processed.

Top module: `slot_mapper_top`

## Requirements
- R1: After `rst` (synchronous, active high), `slot_out` is all zero, `slot_vld` is 0, the summing mode is 00 and all eight channels are powered.
- R2: In mode 00, slot n carries channel n for n = 1..8. Slot k and channel k occupy bits [32k-1:32(k-1)] of `slot_out`, `ch_in` and `casc_in`.
- R3: In mode 01, slot 1 carries (CH1+CH2+CH3+CH4)/4 and slot 2 carries (CH5+CH6+CH7+CH8)/4.
- R4: In mode 10, slots 1 to 4 carry (CH1+CH2)/2, (CH3+CH4)/2, (CH5+CH6)/2 and (CH7+CH8)/2, in that order.
- R5: In mode 11, slot 1 carries the sum of all eight channels divided by 8.
- R6: Each average is the exact sum with 3 guard bits, shifted arithmetically right by 1, 2 or 3 bits (rounding toward minus infinity). It never wraps or saturates, even when every input is at full scale.
- R7: When bit n-1 of the power mask is 0, channel n contributes zero to every slot and every sum.
- R8: With `fmt` = 00 (normal/DSD) or 11, every slot that the mode does not use is zero.
- R9: With `fmt` = 01 (TDM128), slots 5 to 8 are zero in modes 01, 10 and 11. Unused slots among 1 to 4 carry the cascade word of the same slot.
- R10: With `fmt` = 10 (TDM256/512), every unused slot carries the cascade word of the same slot.
- R11: A `cfg_we` pulse loads `cfg_mode` and `cfg_pwr` only when `soft_rst` is 1. When `soft_rst` is 0, the write has no effect.
- R12: A frame presented with `frame_vld` = 1 and `soft_rst` = 0 appears on `slot_out` with `slot_vld` = 1 exactly one clock later. A frame presented while `soft_rst` = 1 produces no `slot_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Soft reset; configuration window, frames dropped |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Summing mode to load |
| cfg_pwr | input | 8 | Per-channel power enables to load (bit n-1 = channel n) |
| fmt | input | 2 | Output format: 00 normal, 01 TDM128, 10 TDM256/512 |
| frame_vld | input | 1 | Channel samples valid this cycle |
| ch_in | input | 256 | Eight signed 32-bit channel samples |
| casc_in | input | 256 | Eight 32-bit cascade words, one per slot |
| slot_out | output | 256 | Eight registered slot words |
| slot_vld | output | 1 | Slot words valid |

## Verification
The hardest situation to reach is an ignored configuration write. Its only visible result is that a later frame is still mapped with the old mode and mask. So the stimulus first sets a known configuration, then writes a very different one with soft reset low. It then sends a frame whose expected words differ clearly between the two configurations. Full-scale positive and negative frames in every summing mode drive the guard bits and the floor rounding. Every format is crossed with every mode, so that the TDM128 split between cascade-filled and zero slots is covered.

// File: rtl/chmap_pkg.sv
package chmap_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'b00,
    MODE_QUAD = 2'b01,
    MODE_PAIR = 2'b10,
    MODE_ALL  = 2'b11
  } sum_mode_e;

  typedef enum logic [1:0] {
    FMT_NORM    = 2'b00,
    FMT_TDM128  = 2'b01,
    FMT_TDMWIDE = 2'b10,
    FMT_RSVD    = 2'b11
  } out_fmt_e;

  localparam int NUM_CH = 8;
  localparam int GUARD  = 3;
endpackage

// File: rtl/chmap_cfg_regs.sv
module chmap_cfg_regs
  import chmap_pkg::*;
#(
  parameter int NCH = NUM_CH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           soft_rst,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_mode,
  input  logic [NCH-1:0] cfg_pwr,
  output sum_mode_e      mode_q,
  output logic [NCH-1:0] pwr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_PASS;
      pwr_q  <= '1;
    end else if (soft_rst && cfg_we) begin
      mode_q <= sum_mode_e'(cfg_mode);
      pwr_q  <= cfg_pwr;
    end
  end

  // R11
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !soft_rst |=> ($stable(mode_q) && $stable(pwr_q)))
    else $error("configuration changed outside soft reset");
endmodule

// File: rtl/chmap_avg.sv
module chmap_avg
  import chmap_pkg::*;
#(
  parameter int W   = 32,
  parameter int NCH = NUM_CH
) (
  input  logic [NCH*W-1:0]   ch_flat,
  input  logic [NCH-1:0]     pwr,
  output logic [NCH*W-1:0]   gated_flat,
  output logic [NCH/2*W-1:0] pair_avg,
  output logic [NCH/4*W-1:0] quad_avg,
  output logic [W-1:0]       all_avg
);
  localparam int SW = W + GUARD;

  logic signed [SW-1:0] ext  [NCH];
  logic signed [SW-1:0] psum [NCH/2];
  logic signed [SW-1:0] qsum [NCH/4];
  logic signed [SW-1:0] tsum;
  logic signed [SW-1:0] tsh;

  for (genvar c = 0; c < NCH; c++) begin : g_gate
    logic [W-1:0] g;
    assign g = pwr[c] ? ch_flat[c*W +: W] : '0;
    assign gated_flat[c*W +: W] = g;
    assign ext[c] = {{GUARD{g[W-1]}}, g};
  end

  for (genvar p = 0; p < NCH/2; p++) begin : g_pair
    logic signed [SW-1:0] sh;
    assign psum[p] = ext[2*p] + ext[2*p+1];
    assign sh = psum[p] >>> 1;
    assign pair_avg[p*W +: W] = sh[W-1:0];
  end

  for (genvar q = 0; q < NCH/4; q++) begin : g_quad
    logic signed [SW-1:0] sh;
    assign qsum[q] = psum[2*q] + psum[2*q+1];
    assign sh = qsum[q] >>> 2;
    assign quad_avg[q*W +: W] = sh[W-1:0];
  end

  assign tsum    = qsum[0] + qsum[1];
  assign tsh     = tsum >>> 3;
  assign all_avg = tsh[W-1:0];
endmodule

// File: rtl/chmap_route.sv
module chmap_route
  import chmap_pkg::*;
#(
  parameter int W   = 32,
  parameter int NCH = NUM_CH
) (
  input  sum_mode_e          mode,
  input  out_fmt_e           fmt,
  input  logic [NCH*W-1:0]   gated_flat,
  input  logic [NCH/2*W-1:0] pair_avg,
  input  logic [NCH/4*W-1:0] quad_avg,
  input  logic [W-1:0]       all_avg,
  input  logic [NCH*W-1:0]   casc_flat,
  output logic [NCH*W-1:0]   slot_flat
);
  for (genvar s = 0; s < NCH; s++) begin : g_slot
    localparam bit LOW_HALF = (s < NCH/2);
    localparam bit QUAD_USE = (s < NCH/4);
    localparam bit ALL_USE  = (s == 0);
    localparam int PI = s % (NCH/2);
    localparam int QI = s % (NCH/4);
    logic         used;
    logic [W-1:0] data_w;
    logic [W-1:0] fill_w;

    always_comb begin
      used   = 1'b0;
      data_w = '0;
      unique case (mode)
        MODE_PASS: begin
          used   = 1'b1;
          data_w = gated_flat[s*W +: W];
        end
        MODE_QUAD: begin
          used   = QUAD_USE;
          data_w = quad_avg[QI*W +: W];
        end
        MODE_PAIR: begin
          used   = LOW_HALF;
          data_w = pair_avg[PI*W +: W];
        end
        MODE_ALL: begin
          used   = ALL_USE;
          data_w = all_avg;
        end
        default: ;
      endcase
    end

    always_comb begin
      if (fmt == FMT_TDMWIDE || (fmt == FMT_TDM128 && LOW_HALF))
        fill_w = casc_flat[s*W +: W];
      else
        fill_w = '0;
    end

    assign slot_flat[s*W +: W] = used ? data_w : fill_w;
  end
endmodule

// File: rtl/slot_mapper_top.sv
module slot_mapper_top
  import chmap_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                soft_rst,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_mode,
  input  logic [NUM_CH-1:0]   cfg_pwr,
  input  logic [1:0]          fmt,
  input  logic                frame_vld,
  input  logic [NUM_CH*W-1:0] ch_in,
  input  logic [NUM_CH*W-1:0] casc_in,
  output logic [NUM_CH*W-1:0] slot_out,
  output logic                slot_vld
);
  localparam int NCH = NUM_CH;

  sum_mode_e            mode_q;
  logic [NCH-1:0]       pwr_q;
  logic [NCH*W-1:0]     gated;
  logic [NCH/2*W-1:0]   pair_avg;
  logic [NCH/4*W-1:0]   quad_avg;
  logic [W-1:0]         all_avg;
  logic [NCH*W-1:0]     slot_d;
  logic                 accept;

  chmap_cfg_regs #(.NCH(NCH)) u_cfg (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_pwr(cfg_pwr), .mode_q(mode_q), .pwr_q(pwr_q)
  );

  chmap_avg #(.W(W), .NCH(NCH)) u_avg (
    .ch_flat(ch_in), .pwr(pwr_q), .gated_flat(gated),
    .pair_avg(pair_avg), .quad_avg(quad_avg), .all_avg(all_avg)
  );

  chmap_route #(.W(W), .NCH(NCH)) u_route (
    .mode(mode_q), .fmt(out_fmt_e'(fmt)), .gated_flat(gated),
    .pair_avg(pair_avg), .quad_avg(quad_avg), .all_avg(all_avg),
    .casc_flat(casc_in), .slot_flat(slot_d)
  );

  assign accept = frame_vld && !soft_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_out <= '0;
      slot_vld <= 1'b0;
    end else begin
      slot_vld <= accept;
      if (accept) slot_out <= slot_d;
    end
  end

  // R12
  frame_lat_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> slot_vld)
    else $error("accepted frame not delivered after one cycle");

  // R12
  frame_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !slot_vld)
    else $error("slot_vld without accepted frame");

  // R8
  norm_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && fmt == 2'b00 && mode_q == MODE_ALL) |=> (slot_out[NCH*W-1:W] == '0))
    else $error("normal format unused slots not zero");

  // R9
  tdm128_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && fmt == 2'b01 && mode_q != MODE_PASS) |=> (slot_out[NCH*W-1:NCH/2*W] == '0))
    else $error("TDM128 upper slots not zero in summing mode");

  // R10
  wide_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && fmt == 2'b10 && mode_q == MODE_ALL) |=>
      (slot_out[NCH*W-1:W] == $past(casc_in[NCH*W-1:W])))
    else $error("wide TDM unused slots not cascaded");

  // R7
  pwr_off_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && mode_q == MODE_PASS && !pwr_q[0]) |=> (slot_out[W-1:0] == '0))
    else $error("unpowered channel 1 leaked to slot 1");
endmodule

// File: tb/tb_slot_mapper_top.sv
module tb_slot_mapper_top;
  localparam int W = 32;
  localparam int N = 8;

  logic clk = 0;
  logic rst = 1;
  logic soft_rst = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_mode = 0;
  logic [N-1:0] cfg_pwr = 0;
  logic [1:0] fmt = 0;
  logic frame_vld = 0;
  logic [N*W-1:0] ch_in = 0;
  logic [N*W-1:0] casc_in = 0;
  logic [N*W-1:0] slot_out;
  logic slot_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0]   tb_mode = 0;
  logic [N-1:0] tb_pwr = '1;

  logic [N*W-1:0] exp_q[$];
  string          tag_q[$];

  always #4 clk = ~clk;

  slot_mapper_top #(.W(W)) dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_pwr(cfg_pwr), .fmt(fmt), .frame_vld(frame_vld),
    .ch_in(ch_in), .casc_in(casc_in), .slot_out(slot_out), .slot_vld(slot_vld)
  );

  function automatic logic [N*W-1:0] model(logic [1:0] m, logic [N-1:0] p,
      logic [1:0] f, logic [N*W-1:0] ch, logic [N*W-1:0] cs);
    longint v[N];
    logic [N*W-1:0] r;
    for (int c = 0; c < N; c++)
      v[c] = p[c] ? longint'($signed(ch[c*W +: W])) : 64'sd0;
    for (int s = 0; s < N; s++) begin
      if (f == 2'b10 || (f == 2'b01 && s < 4)) r[s*W +: W] = cs[s*W +: W];
      else r[s*W +: W] = '0;
    end
    case (m)
      2'b00: for (int s = 0; s < N; s++) r[s*W +: W] = W'(v[s]);
      2'b01: begin
        r[0 +: W] = W'((v[0] + v[1] + v[2] + v[3]) >>> 2);
        r[W +: W] = W'((v[4] + v[5] + v[6] + v[7]) >>> 2);
      end
      2'b10: for (int s = 0; s < 4; s++) r[s*W +: W] = W'((v[2*s] + v[2*s+1]) >>> 1);
      default: r[0 +: W] = W'((v[0]+v[1]+v[2]+v[3]+v[4]+v[5]+v[6]+v[7]) >>> 3);
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop and compare whenever a frame comes out
  always @(negedge clk) begin
    if (!rst && !done && slot_vld) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 actual=unexpected slot_vld expected=none");
      end else begin
        check(tag_q.pop_front(), slot_out, exp_q.pop_front());
      end
    end
  end

  task automatic configure(logic [1:0] m, logic [N-1:0] p);
    @(negedge clk);
    soft_rst = 1; cfg_we = 1; cfg_mode = m; cfg_pwr = p;
    @(negedge clk);
    cfg_we = 0; soft_rst = 0;
    tb_mode = m; tb_pwr = p;
  endtask

  // driver: present one frame and push its expected slot words
  task automatic send(string req, logic [1:0] f, logic [N*W-1:0] ch, logic [N*W-1:0] cs);
    @(negedge clk);
    fmt = f; ch_in = ch; casc_in = cs; frame_vld = 1;
    exp_q.push_back(model(tb_mode, tb_pwr, f, ch, cs));
    tag_q.push_back(req);
    @(negedge clk);
    frame_vld = 0;
    check({req, " R12 slot_vld"}, {{(N*W-1){1'b0}}, slot_vld}, {{(N*W-1){1'b0}}, 1'b1});
  endtask

  function automatic logic [N*W-1:0] rnd();
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = $urandom;
    return r;
  endfunction

  function automatic logic [N*W-1:0] fill(logic [W-1:0] x);
    return {N{x}};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 slot_out", slot_out, '0);
    check("R1 slot_vld", {{(N*W-1){1'b0}}, slot_vld}, '0);
    send("R1 default config", 2'b00, rnd(), rnd());

    // R2 pass-through in every format
    for (int f = 0; f < 3; f++) send("R2 pass", 2'(f), rnd(), rnd());

    // R3 R4 R5 across formats (R8 R9 R10 fills)
    for (int m = 1; m < 4; m++) begin
      configure(2'(m), '1);
      send("R8 normal fill", 2'b00, rnd(), rnd());
      send("R9 tdm128 fill", 2'b01, rnd(), rnd());
      send("R10 wide fill", 2'b10, rnd(), rnd());
      send("R8 reserved fmt", 2'b11, rnd(), rnd());
      if (m == 1) send("R3 quad avg", 2'b00, rnd(), rnd());
      if (m == 2) send("R4 pair avg", 2'b00, rnd(), rnd());
      if (m == 3) send("R5 total avg", 2'b00, rnd(), rnd());
      // R6 full scale and floor rounding
      send("R6 max pos", 2'b00, fill(32'h7FFF_FFFF), rnd());
      send("R6 max neg", 2'b00, fill(32'h8000_0000), rnd());
      send("R6 floor", 2'b00, {{7{32'h0}}, 32'hFFFF_FFFF}, rnd());
    end

    // R7 power gating
    configure(2'b00, 8'b1010_0110);
    send("R7 pass gated", 2'b00, rnd(), rnd());
    configure(2'b11, 8'b0111_1110);
    send("R7 total gated", 2'b10, fill(32'h4000_0001), rnd());
    configure(2'b10, 8'b0000_0000);
    send("R7 all off", 2'b01, rnd(), rnd());

    // R11 write outside soft reset ignored
    configure(2'b01, 8'hF0);
    @(negedge clk);
    cfg_we = 1; cfg_mode = 2'b00; cfg_pwr = 8'h0F;
    @(negedge clk);
    cfg_we = 0;
    send("R11 ignored write", 2'b00, rnd(), rnd());
    send("R11 ignored write tdm", 2'b10, rnd(), rnd());

    // R12 frame during soft reset dropped
    @(negedge clk);
    soft_rst = 1; frame_vld = 1; ch_in = rnd();
    @(negedge clk);
    frame_vld = 0;
    check("R12 dropped frame", {{(N*W-1){1'b0}}, slot_vld}, '0);
    soft_rst = 0;

    // R12 back-to-back frames
    configure(2'b00, '1);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      logic [N*W-1:0] c, d;
      c = rnd(); d = rnd();
      fmt = 2'b00; ch_in = c; casc_in = d; frame_vld = 1;
      exp_q.push_back(model(tb_mode, tb_pwr, 2'b00, c, d));
      tag_q.push_back("R12 back-to-back");
      @(negedge clk);
    end
    frame_vld = 0;
    repeat (3) @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12 actual=%0d pending expected=0", exp_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule